// File: doc/BRIEF.md
# DMA Destination Address and Acknowledge Control

This block is the per-channel control slice of a four-channel DMA controller. Each channel holds a destination address register and a small control register. The control register has a destination mode field (fixed, increment or decrement). The two lowest channels also have an acknowledge timing bit and an acknowledge polarity bit. When a transfer completes, the destination address moves by a step that follows the channel's transfer size: 1 or 2 bytes, a word of 4 bytes, or a 16-byte block.

The block also drives one acknowledge strobe per channel, with the programmed polarity. In dual address mode the strobe follows either the read phase or the write phase of the transfer. In single address mode it follows both phases. Combinations that are not allowed leave the address untouched and raise a per-channel configuration error flag.

Software reaches the registers through a simple write port and a combinational read port. A channel index selects the channel, and a one-bit field select picks either the control register or the destination address.

Top module: `dma_dst_ack_ctl`

## Requirements
- R1: After reset every destination address and control register reads 0, every `config_error` is 0, and every `dack` is high (inactive in active-low polarity). The control register layout is: bits [1:0] destination mode, bit 4 acknowledge timing, bit 5 acknowledge polarity, all other bits reading 0. `reg_field` 0 selects the control register and 1 selects the destination address.
- R2: With destination mode 01 (increment), a `xfer_done` pulse sampled at a rising edge adds the step to the address. The step is 1 for size code 00, 2 for 01, 4 for 10 and 16 for 11. The new value is readable after that edge.
- R3: With destination mode 10 (decrement), a `xfer_done` pulse subtracts 1 for size 00, 2 for size 01 and 4 for size 10.
- R4: With destination mode 00 (fixed), `xfer_done` leaves the address unchanged.
- R5: Mode 11, or mode 10 together with size 11, drives that channel's `config_error` high while the combination is present. A `xfer_done` pulse then leaves the address unchanged.
- R6: Address arithmetic wraps modulo 2^32 in both directions.
- R7: In dual address mode (`dual_mode`=1) on a channel with acknowledge controls, timing bit 0 asserts `dack` exactly while `rd_cycle` is high. Timing bit 1 asserts it exactly while `wr_cycle` is high.
- R8: In single address mode (`dual_mode`=0), `dack` is asserted while either `rd_cycle` or `wr_cycle` is high, whatever the timing bit holds.
- R9: Polarity bit 0 makes `dack` active-low and polarity bit 1 makes it active-high. Whenever the strobe is not asserted, `dack` sits at the inactive level for the programmed polarity.
- R10: On channels 2 and 3, writes to control bits 4 and 5 are ignored and those bits read 0. These channels behave as timing 0 with active-low polarity.
- R11: A register write to a destination address in the same cycle as that channel's `xfer_done` takes priority: the written value is loaded and no step is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Channel index for register access |
| reg_field | input | 1 | 0 = control register, 1 = destination address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xfer_size | input | 8 | Per-channel 2-bit transfer size code, channel n at bits [2n+1:2n] |
| dual_mode | input | 4 | Per-channel 1 = dual address mode, 0 = single |
| xfer_done | input | 4 | Per-channel transfer-complete pulse |
| rd_cycle | input | 4 | Per-channel read phase indication |
| wr_cycle | input | 4 | Per-channel write phase indication |
| dack | output | 4 | Per-channel acknowledge strobe |
| config_error | output | 4 | Per-channel illegal-configuration flag |

## Verification
A wrong step, direction or wrap shows up in the destination address one clock after the completing pulse. The bench reads the address back through the register port right then. A mode or size decode fault shows up at once on `config_error`, or as an address that moves when it should stay put. Wrong acknowledge timing or polarity is combinational, so it is visible at `dack` in the same cycle as the phase indication. Stray state in the upper channels' acknowledge bits would show in the control readback and in `dack` under write phases.

// File: rtl/dmac_dst_pkg.sv
package dmac_dst_pkg;

  typedef enum logic [1:0] {
    DM_FIXED = 2'b00,
    DM_INC   = 2'b01,
    DM_DEC   = 2'b10,
    DM_BAD   = 2'b11
  } dst_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BLK  = 2'b11
  } xfer_size_e;

  localparam int CTRL_DM_LSB = 0;
  localparam int CTRL_AM_BIT = 4;
  localparam int CTRL_AL_BIT = 5;

  function automatic logic [4:0] step_bytes(input xfer_size_e sz);
    case (sz)
      SZ_BYTE: step_bytes = 5'd1;
      SZ_HALF: step_bytes = 5'd2;
      SZ_WORD: step_bytes = 5'd4;
      default: step_bytes = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dst_step_calc.sv
module dst_step_calc
  import dmac_dst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  dst_mode_e         mode,
  input  xfer_size_e        size,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              cfg_err
);

  logic [ADDR_W-1:0] step;

  always_comb begin
    step = ADDR_W'(step_bytes(size));
    cfg_err = (mode == DM_BAD) || ((mode == DM_DEC) && (size == SZ_BLK));
    nxt_addr = cur_addr;
    if (!cfg_err) begin
      case (mode)
        DM_INC:  nxt_addr = cur_addr + step;
        DM_DEC:  nxt_addr = cur_addr - step;
        default: nxt_addr = cur_addr;
      endcase
    end
  end

endmodule

// File: rtl/dst_chan_regs.sv
module dst_chan_regs
  import dmac_dst_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter bit HAS_ACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              addr_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  input  xfer_size_e        size,
  output dst_mode_e         dm,
  output logic              am,
  output logic              al,
  output logic [ADDR_W-1:0] addr,
  output logic              cfg_err
);

  dst_mode_e         dm_q, dm_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] step_addr;

  dst_step_calc #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr (addr_q),
    .mode     (dm_q),
    .size     (size),
    .nxt_addr (step_addr),
    .cfg_err  (cfg_err)
  );

  always_comb begin
    dm_d = dm_q;
    if (ctrl_we) dm_d = dst_mode_e'(wdata[CTRL_DM_LSB +: 2]);
  end

  always_comb begin
    addr_d = addr_q;
    if (addr_we)   addr_d = wdata[ADDR_W-1:0];
    else if (done) addr_d = step_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_q   <= DM_FIXED;
      addr_q <= '0;
    end else begin
      dm_q   <= dm_d;
      addr_q <= addr_d;
    end
  end

  generate
    if (HAS_ACK) begin : g_ack_bits
      logic am_q, am_d, al_q, al_d;
      always_comb begin
        am_d = am_q;
        al_d = al_q;
        if (ctrl_we) begin
          am_d = wdata[CTRL_AM_BIT];
          al_d = wdata[CTRL_AL_BIT];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          am_q <= 1'b0;
          al_q <= 1'b0;
        end else begin
          am_q <= am_d;
          al_q <= al_d;
        end
      end
      assign am = am_q;
      assign al = al_q;
    end else begin : g_no_ack_bits
      assign am = 1'b0;
      assign al = 1'b0;
    end
  endgenerate

  assign dm   = dm_q;
  assign addr = addr_q;

  // R4 R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_we && (!done || cfg_err || dm_q == DM_FIXED)) |=> $stable(addr_q));

  // R11
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (addr_q == $past(wdata[ADDR_W-1:0])));

  // R2
  blk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_we && done && dm_q == DM_INC && size == SZ_BLK)
      |=> (addr_q[3:0] == $past(addr_q[3:0])));

endmodule

// File: rtl/dst_ack_gen.sv
module dst_ack_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic dual,
  input  logic am,
  input  logic al,
  input  logic rd,
  input  logic wr,
  output logic dack
);

  logic active;

  always_comb begin
    if (dual) active = am ? wr : rd;
    else      active = rd | wr;
    dack = active ? al : ~al;
  end

  // R8
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual && (rd || wr)) |-> (dack == al));

  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr) |-> (dack == !al));

  // R7
  dual_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && (rd != wr)) |-> ((dack == al) == (am ? wr : rd)));

endmodule

// File: rtl/dma_dst_ack_ctl.sv
module dma_dst_ack_ctl
  import dmac_dst_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_ACK_CH = 2,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  localparam int SEL_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic                reg_field,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [2*NUM_CH-1:0] xfer_size,
  input  logic [NUM_CH-1:0]   dual_mode,
  input  logic [NUM_CH-1:0]   xfer_done,
  input  logic [NUM_CH-1:0]   rd_cycle,
  input  logic [NUM_CH-1:0]   wr_cycle,
  output logic [NUM_CH-1:0]   dack,
  output logic [NUM_CH-1:0]   config_error
);

  dst_mode_e         ch_dm   [NUM_CH];
  logic              ch_am   [NUM_CH];
  logic              ch_al   [NUM_CH];
  logic [ADDR_W-1:0] ch_addr [NUM_CH];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic ctrl_we, addr_we;
      assign ctrl_we = reg_wr && (reg_sel == SEL_W'(gi)) && !reg_field;
      assign addr_we = reg_wr && (reg_sel == SEL_W'(gi)) &&  reg_field;

      dst_chan_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .HAS_ACK(gi < NUM_ACK_CH)
      ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .addr_we (addr_we),
        .wdata   (reg_wdata),
        .done    (xfer_done[gi]),
        .size    (xfer_size_e'(xfer_size[2*gi +: 2])),
        .dm      (ch_dm[gi]),
        .am      (ch_am[gi]),
        .al      (ch_al[gi]),
        .addr    (ch_addr[gi]),
        .cfg_err (config_error[gi])
      );

      dst_ack_gen u_ack (
        .clk  (clk),
        .rst_n(rst_n),
        .dual (dual_mode[gi]),
        .am   (ch_am[gi]),
        .al   (ch_al[gi]),
        .rd   (rd_cycle[gi]),
        .wr   (wr_cycle[gi]),
        .dack (dack[gi])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_sel == SEL_W'(c)) begin
        if (reg_field) begin
          reg_rdata = DATA_W'(ch_addr[c]);
        end else begin
          reg_rdata[CTRL_DM_LSB +: 2] = ch_dm[c];
          reg_rdata[CTRL_AM_BIT]      = ch_am[c];
          reg_rdata[CTRL_AL_BIT]      = ch_al[c];
        end
      end
    end
  end

  // R10
  upper_ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(reg_sel) >= NUM_ACK_CH) && !reg_field)
      |-> (reg_rdata[CTRL_AL_BIT:CTRL_AM_BIT] == 2'b00));

endmodule

// File: tb/dma_dst_ack_ctl_tb_top.sv
module dma_dst_ack_ctl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic        reg_field;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  xfer_size;
  logic [3:0]  dual_mode, xfer_done, rd_cycle, wr_cycle, dack, config_error;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_dst_ack_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_field(reg_field), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_size(xfer_size), .dual_mode(dual_mode), .xfer_done(xfer_done),
    .rd_cycle(rd_cycle), .wr_cycle(wr_cycle), .dack(dack),
    .config_error(config_error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int ch, input bit fld, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'(ch); reg_field = fld; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input bit fld, output logic [31:0] v);
    reg_sel = 2'(ch); reg_field = fld;
    #1 v = reg_rdata;
  endtask

  task automatic pulse_done(input int ch);
    @(negedge clk);
    xfer_done[ch] = 1'b1;
    @(negedge clk);
    xfer_done[ch] = 1'b0;
  endtask

  task automatic step_case(input string req, input int ch, input logic [1:0] mode,
                           input logic [1:0] sz, input logic [31:0] start,
                           input logic [31:0] exp);
    logic [31:0] v;
    wr_reg(ch, 1'b0, {30'd0, mode});
    wr_reg(ch, 1'b1, start);
    xfer_size[2*ch +: 2] = sz;
    pulse_done(ch);
    rd_reg(ch, 1'b1, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      rd_reg(c, 1'b0, v); chk("R1 ctrl", v, 0);
      rd_reg(c, 1'b1, v); chk("R1 addr", v, 0);
    end
    #1;
    chk("R1 dack", {28'd0, dack}, 32'hF);
    chk("R1 err", {28'd0, config_error}, 0);
  endtask

  task automatic t_increment;
    step_case("R2 inc byte", 0, 2'b01, 2'b00, 32'h100, 32'h101);
    step_case("R2 inc half", 0, 2'b01, 2'b01, 32'h100, 32'h102);
    step_case("R2 inc word", 1, 2'b01, 2'b10, 32'h100, 32'h104);
    step_case("R2 inc blk",  2, 2'b01, 2'b11, 32'h100, 32'h110);
  endtask

  task automatic t_decrement;
    step_case("R3 dec byte", 3, 2'b10, 2'b00, 32'h100, 32'h0FF);
    step_case("R3 dec half", 0, 2'b10, 2'b01, 32'h100, 32'h0FE);
    step_case("R3 dec word", 1, 2'b10, 2'b10, 32'h100, 32'h0FC);
  endtask

  task automatic t_fixed;
    step_case("R4 fixed", 2, 2'b00, 2'b10, 32'hABC0, 32'hABC0);
  endtask

  task automatic t_errors;
    step_case("R5 bad mode addr", 1, 2'b11, 2'b00, 32'h200, 32'h200);
    #1 chk("R5 bad mode flag", {31'd0, config_error[1]}, 1);
    step_case("R5 dec blk addr", 2, 2'b10, 2'b11, 32'h300, 32'h300);
    #1 chk("R5 dec blk flag", {31'd0, config_error[2]}, 1);
    xfer_size[5:4] = 2'b10;
    #1 chk("R5 flag clears", {31'd0, config_error[2]}, 0);
  endtask

  task automatic t_wrap;
    step_case("R6 wrap up", 0, 2'b01, 2'b10, 32'hFFFF_FFFE, 32'h0000_0002);
    step_case("R6 wrap down", 1, 2'b10, 2'b01, 32'h0000_0001, 32'hFFFF_FFFF);
  endtask

  task automatic t_ack_dual;
    wr_reg(0, 1'b0, 32'h0);
    dual_mode[0] = 1'b1;
    rd_cycle[0] = 1'b1; #1 chk("R7 am0 rd", {31'd0, dack[0]}, 0);
    rd_cycle[0] = 1'b0; wr_cycle[0] = 1'b1;
    #1 chk("R7 am0 wr", {31'd0, dack[0]}, 1);
    wr_cycle[0] = 1'b0;
    wr_reg(0, 1'b0, 32'h10);
    rd_cycle[0] = 1'b1; #1 chk("R7 am1 rd", {31'd0, dack[0]}, 1);
    rd_cycle[0] = 1'b0; wr_cycle[0] = 1'b1;
    #1 chk("R7 am1 wr", {31'd0, dack[0]}, 0);
    wr_cycle[0] = 1'b0;
  endtask

  task automatic t_ack_single;
    wr_reg(1, 1'b0, 32'h10);
    dual_mode[1] = 1'b0;
    rd_cycle[1] = 1'b1; #1 chk("R8 single rd", {31'd0, dack[1]}, 0);
    rd_cycle[1] = 1'b0; wr_cycle[1] = 1'b1;
    #1 chk("R8 single wr", {31'd0, dack[1]}, 0);
    wr_cycle[1] = 1'b0;
  endtask

  task automatic t_polarity;
    logic [31:0] v;
    wr_reg(1, 1'b0, 32'h20);
    rd_reg(1, 1'b0, v); chk("R9 ctrl readback", v, 32'h20);
    dual_mode[1] = 1'b1;
    #1 chk("R9 idle high-pol", {31'd0, dack[1]}, 0);
    rd_cycle[1] = 1'b1; #1 chk("R9 active high", {31'd0, dack[1]}, 1);
    rd_cycle[1] = 1'b0;
  endtask

  task automatic t_upper;
    logic [31:0] v;
    wr_reg(3, 1'b0, 32'h31);
    rd_reg(3, 1'b0, v); chk("R10 upper ctrl", v, 32'h01);
    dual_mode[3] = 1'b1;
    wr_cycle[3] = 1'b1; #1 chk("R10 upper wr", {31'd0, dack[3]}, 1);
    wr_cycle[3] = 1'b0;
    rd_cycle[3] = 1'b1; #1 chk("R10 upper rd", {31'd0, dack[3]}, 0);
    rd_cycle[3] = 1'b0;
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr_reg(0, 1'b0, 32'h1);
    xfer_size[1:0] = 2'b10;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_field = 1'b1; reg_wdata = 32'h5000;
    xfer_done[0] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; xfer_done[0] = 1'b0;
    rd_reg(0, 1'b1, v); chk("R11 write wins", v, 32'h5000);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_field = 1'b0;
    reg_wdata = '0; xfer_size = '0; dual_mode = '0; xfer_done = '0;
    rd_cycle = '0; wr_cycle = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_increment();
    t_decrement();
    t_fixed();
    t_errors();
    t_wrap();
    t_ack_dual();
    t_ack_single();
    t_polarity();
    t_upper();
    t_priority();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule